// File: doc/BRIEF.md
# UART Interrupt Status Register Bank

This block gathers ten single-cycle event pulses from a UART core and turns them into sticky raw status flags. An enable mask selects which flags may reach the interrupt line. The masked status is the bitwise AND of the raw flags and the mask. One interrupt output is raised while any masked flag is set. Software clears flags by writing ones to a dedicated clear register.

Four registers sit on a plain register port. The port carries a write strobe, an address, write data, and combinational read data for the presented address. Reads have no side effects. The port has no handshake and never stalls, so it applies no back-pressure: a write is taken on the rising clock edge at which the strobe is high.

Top module: `uart_irq_bank`

## Requirements
- R1: After reset the mask and all raw flags are zero, `irq_o` is low, and every register reads as zero.
- R2: An event pulse on `evt_i[i]` at a rising edge sets raw flag i, visible from that edge on. The flag stays set without further pulses until it is cleared.
- R3: The raw status register at offset 0xFF08 shows every flag whether or not its mask bit is set.
- R4: A write to offset 0xFF00 loads the mask from `reg_wdata`, where 1 enables a source and 0 disables it. A read at 0xFF00 returns the mask.
- R5: A read at offset 0xFF04 returns the raw flags ANDed with the mask.
- R6: A write to offset 0xFF0C clears each raw flag whose data bit is 1 and leaves the other flags unchanged. That offset reads as zero.
- R7: When an event pulse and a clear of the same bit fall on the same edge, the flag is set after that edge.
- R8: Writes to offsets 0xFF04 and 0xFF08 change neither the flags nor the mask.
- R9: `irq_o` is high exactly when at least one masked status bit is 1.
- R10: Register bit i corresponds to `evt_i[i]`, with 0 TX empty, 1 RX full, 2 TX below threshold, 3 RX above threshold, 4 break, 5 match, 6 framing error, 7 parity error, 8 overrun, and 9 receiver timeout. Read bits above bit 9 are zero, and addresses other than the four offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC (10) | Event pulses from the UART core, one per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (16) | Register byte offset |
| reg_wdata | input | N_SRC (10) | Write data; only the flag bits exist |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, zero-extended |
| irq_o | output | 1 | Interrupt request, OR of the masked status |

## Verification
A stuck, lost or wrongly set flag shows at the raw-status read, and at the interrupt pin once that source is enabled. Because flags are sticky, the fault stays visible from the first edge after it arises. A mask fault shows at once in the masked-status read and in `irq_o`. Because the read path is combinational, the reference model is compared with the read data and the interrupt line on every cycle, and the presented address rotates across all four offsets.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned N_SRC  = 10;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  localparam logic [15:0] OFF_MASK   = 16'hFF00;
  localparam logic [15:0] OFF_MASKED = 16'hFF04;
  localparam logic [15:0] OFF_RAW    = 16'hFF08;
  localparam logic [15:0] OFF_CLEAR  = 16'hFF0C;

  typedef enum int unsigned {
    SRC_TX_EMPTY  = 0,
    SRC_RX_FULL   = 1,
    SRC_TX_BELOW  = 2,
    SRC_RX_ABOVE  = 3,
    SRC_BREAK     = 4,
    SRC_MATCH     = 5,
    SRC_FRAME_ERR = 6,
    SRC_PAR_ERR   = 7,
    SRC_OVERRUN   = 8,
    SRC_RX_TMO    = 9
  } irq_src_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          sel_mask,
  output logic          sel_masked,
  output logic          sel_raw,
  output logic          wr_mask,
  output logic          wr_clear
);
  logic hit_clear;

  always_comb begin
    sel_mask   = (addr == AW'(OFF_MASK));
    sel_masked = (addr == AW'(OFF_MASKED));
    sel_raw    = (addr == AW'(OFF_RAW));
    hit_clear  = (addr == AW'(OFF_CLEAR));
    wr_mask    = wr & sel_mask;
    wr_clear   = wr & hit_clear;
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned N  = 10,
  parameter int unsigned DW = 32
) (
  input  logic          sel_mask,
  input  logic          sel_masked,
  input  logic          sel_raw,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  masked,
  input  logic [N-1:0]  raw,
  output logic [DW-1:0] rdata
);
  localparam int unsigned PAD = DW - N;

  logic [N-1:0] pick;

  always_comb begin
    pick = ({N{sel_mask}} & mask) | ({N{sel_masked}} & masked) | ({N{sel_raw}} & raw);
    rdata = {{PAD{1'b0}}, pick};
  end
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uart_irq_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] evt_i,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [NS-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  logic sel_mask, sel_masked, sel_raw, wr_mask, wr_clear;
  logic [NS-1:0] mask_q;
  logic [NS-1:0] raw_q;
  logic [NS-1:0] masked;

  irq_addr_dec #(.AW(AW)) dec_i (
    .wr(reg_wr), .addr(reg_addr),
    .sel_mask(sel_mask), .sel_masked(sel_masked), .sel_raw(sel_raw),
    .wr_mask(wr_mask), .wr_clear(wr_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  for (genvar g = 0; g < NS; g++) begin : g_flag
    irq_flag_cell cell_i (
      .clk(clk), .rst_n(rst_n),
      .set_i(evt_i[g]),
      .clr_i(wr_clear & reg_wdata[g]),
      .flag_o(raw_q[g])
    );
  end

  assign masked = raw_q & mask_q;
  assign irq_o  = |masked;

  irq_read_mux #(.N(NS), .DW(DW)) rmux_i (
    .sel_mask(sel_mask), .sel_masked(sel_masked), .sel_raw(sel_raw),
    .mask(mask_q), .masked(masked), .raw(raw_q),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/uart_irq_bank_chk.sv
module uart_irq_bank_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NS-1:0] evt_i,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [NS-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_o,
  input logic [NS-1:0] raw_q,
  input logic [NS-1:0] mask_q
);
  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R6
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_CLEAR))
      |=> ((raw_q & $past(reg_wdata & ~evt_i)) == '0));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFF_MASK)) |=> (mask_q == $past(reg_wdata)));

  // R8
  ro_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == AW'(OFF_MASKED) || reg_addr == AW'(OFF_RAW)) && evt_i == '0)
      |=> (raw_q == $past(raw_q) && mask_q == $past(mask_q)));

  // R9
  irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(OFF_MASKED)) |-> ((reg_rdata != '0) == irq_o));

  // R10
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:NS] == '0);
endmodule

bind uart_irq_bank uart_irq_bank_chk #(.NS(NS), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/uart_irq_bank_tb.sv
module uart_irq_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] evt_i = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [NS-1:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  bit [NS-1:0] m_mask = '0;
  bit [NS-1:0] m_raw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [15:0] a);
    case (a)
      16'hFF00: return {22'd0, m_mask};
      16'hFF04: return {22'd0, m_raw & m_mask};
      16'hFF08: return {22'd0, m_raw};
      default:  return 32'd0;
    endcase
  endfunction

  // One cycle: drive at falling edge, compare before the rising edge, then advance the model.
  task automatic step(string req, logic [NS-1:0] ev, logic wr, logic [15:0] a, logic [NS-1:0] wd);
    @(negedge clk);
    evt_i = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    chk(req, reg_rdata, model_read(a));
    chk("R9", {31'd0, irq_o}, {31'd0, |(m_raw & m_mask)});
    @(posedge clk);
    if (wr && a == 16'hFF00) m_mask = wd;
    if (wr && a == 16'hFF0C) m_raw = m_raw & ~wd;
    m_raw = m_raw | ev;
  endtask

  task automatic rd(string req, logic [15:0] a, logic [31:0] lit);
    @(negedge clk);
    evt_i = '0; reg_wr = 0; reg_addr = a;
    #1;
    chk(req, reg_rdata, lit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 16'hFF00, 0); rd("R1", 16'hFF04, 0); rd("R1", 16'hFF08, 0); rd("R1", 16'hFF0C, 0);
    chk("R1", {31'd0, irq_o}, 0);
    // R2 event sets and holds
    step("R2", 10'h008, 0, 16'hFF08, 0);
    for (int i = 0; i < 4; i++) step("R2", 0, 0, 16'hFF08, 0);
    rd("R2", 16'hFF08, 32'h008);
    // R3 raw visible with mask zero
    step("R3", 10'h300, 0, 16'hFF08, 0);
    rd("R3", 16'hFF08, 32'h308);
    rd("R5", 16'hFF04, 32'h000);
    // R4 mask write and readback
    step("R4", 0, 1, 16'hFF00, 10'h10C);
    rd("R4", 16'hFF00, 32'h10C);
    // R5 masked status
    rd("R5", 16'hFF04, 32'h108);
    chk("R9", {31'd0, irq_o}, 1);
    // R6 clear subset
    step("R6", 0, 1, 16'hFF0C, 10'h108);
    rd("R6", 16'hFF08, 32'h200);
    rd("R6", 16'hFF0C, 32'h000);
    chk("R9", {31'd0, irq_o}, 0);
    // R7 event wins over clear
    step("R7", 10'h004, 1, 16'hFF0C, 10'h204);
    rd("R7", 16'hFF08, 32'h004);
    chk("R9", {31'd0, irq_o}, 1);
    // R8 writes to status offsets are inert
    step("R8", 0, 1, 16'hFF04, 10'h3FF);
    step("R8", 0, 1, 16'hFF08, 10'h000);
    rd("R8", 16'hFF08, 32'h004);
    rd("R8", 16'hFF00, 32'h10C);
    // R10 each source index maps to its own bit
    step("R10", 0, 1, 16'hFF0C, 10'h3FF);
    for (int i = 0; i < NS; i++) begin
      step("R10", 10'(1 << i), 0, 16'hFF08, 0);
      rd("R10", 16'hFF08, 32'(1 << i));
      step("R10", 0, 1, 16'hFF0C, 10'(1 << i));
    end
    step("R10", 10'h3FF, 0, 16'hFF10, 0);
    rd("R10", 16'hFF10, 0);
    rd("R10", 16'h0000, 0);
    // R5 mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'hFF00 + 16'(4 * ($urandom % 5));
      step("R5", 10'($urandom) & 10'($urandom), 1'($urandom), a, 10'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule